// File: doc/BRIEF.md
# Two-Level Thermal Supervisor

This block watches a stream of die-temperature samples, each a signed integer in degrees Celsius marked by a sample-valid strobe. It keeps two separate hysteretic states. The first is a warning. It drives an active-low flag that is suited to an open-drain pin, and switching carries on as normal while it is set. The second is a shutdown request. While it is set, both gate drive outputs of the power stage are held off. It clears by itself once the die has cooled far enough.

Each state has its own trip point and its own hysteresis, and both are parameters. The warning trips when the temperature reaches its threshold. The shutdown trips only when the temperature goes above its threshold. Each state releases only when the temperature is strictly below its trip point minus its hysteresis. A sample equal to a release point leaves the state as it was. Both states update on a clock edge, and only when the strobe is high. The high-side and low-side gate requests from the sequencer pass through a mask that is driven by the shutdown state.

Top module: `thermal_supervisor`

## Requirements
- R1: After reset, `warn_n` is 1 and `shdn_req` is 0.
- R2: A valid sample at 150 or above makes `warn_n` go to 0 on the clock edge that takes the sample. A sample of 149 does not.
- R3: Once set, the warning releases (`warn_n` goes back to 1) only on a valid sample strictly below 135. Samples from 135 to 149 hold it at 0.
- R4: A valid sample strictly above 180 sets `shdn_req` to 1 on the clock edge that takes the sample. A sample of exactly 180 does not.
- R5: Once set, the shutdown clears only on a valid sample strictly below 155. A sample of 155 holds it.
- R6: A sample taken while `temp_valid` is 0 changes neither state, whatever its value.
- R7: While `shdn_req` is 1, `hs_gate` and `ls_gate` are both 0, whatever the requests are.
- R8: While `shdn_req` is 0, `hs_gate` equals `hs_req` and `ls_gate` equals `ls_req` in the same cycle, whether or not the warning is set.
- R9: The two states are independent. For example, the shutdown can clear at 154 while the warning stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_valid | input | 1 | Qualifies `temp_c` in this cycle |
| temp_c | input | TEMP_W | Die temperature, signed, in degrees Celsius |
| hs_req | input | 1 | High-side gate request from the sequencer |
| ls_req | input | 1 | Low-side gate request from the sequencer |
| warn_n | output | 1 | Thermal warning, active low |
| shdn_req | output | 1 | Thermal shutdown request, active high |
| hs_gate | output | 1 | Masked high-side gate drive |
| ls_gate | output | 1 | Masked low-side gate drive |

## Verification
`warn_n` and `shdn_req` are registered. They change at the edge that captures a valid sample, so the bench checks them 1 ns after that edge, before the next sample is driven. The gate outputs are combinational from the requests and the registered shutdown state. The bench therefore checks them 1 ns after driving new requests, against the shutdown state from the previous edge. Directed steps hit each trip point and release point, including the exact-equality cases. A full up-and-down sweep from -40 to 200 °C, with a strobe pattern that skips some samples, is compared against an arithmetic model in the bench.

// File: rtl/thermal_sup_pkg.sv
package thermal_sup_pkg;
   // Which comparison trips a hysteretic level
   typedef enum logic {
      TRIP_AT_OR_ABOVE = 1'b0,
      TRIP_ABOVE       = 1'b1
   } trip_mode_e;
endpackage

// File: rtl/thermal_hyst_cmp.sv
module thermal_hyst_cmp
   import thermal_sup_pkg::*;
#(
   parameter int         TEMP_W = 10,
   parameter int         TRIP   = 150,
   parameter int         HYST   = 15,
   parameter trip_mode_e MODE   = TRIP_AT_OR_ABOVE
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid,
   input  logic signed [TEMP_W-1:0] temp,
   output logic                     active
);
   localparam int TMAX    = (1 << (TEMP_W - 1)) - 1;
   localparam int TMIN    = -(1 << (TEMP_W - 1));
   localparam int RELEASE = TRIP - HYST;

   if (HYST < 1) begin : g_bad_hyst
      $error("thermal_hyst_cmp: HYST must be at least 1");
   end
   if (TRIP > TMAX || TRIP < TMIN) begin : g_bad_trip
      $error("thermal_hyst_cmp: TRIP does not fit TEMP_W");
   end
   if (RELEASE <= TMIN) begin : g_bad_rel
      $error("thermal_hyst_cmp: release point below representable range");
   end

   logic hot, cool, act_q;

   if (MODE == TRIP_ABOVE) begin : g_strict
      assign hot = temp > TRIP;
   end else begin : g_incl
      assign hot = temp >= TRIP;
   end
   assign cool = temp < RELEASE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (valid) begin
         if (!act_q && hot) begin
            act_q <= 1'b1;
         end else if (act_q && cool) begin
            act_q <= 1'b0;
         end
      end
   end

   assign active = act_q;

   // R2 R4: a rise needs a valid sample past the trip point
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(valid) &&
         ((MODE == TRIP_ABOVE) ? ($past(temp) > TRIP) : ($past(temp) >= TRIP)));

   // R3 R5: a fall needs a valid sample strictly below release
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> $past(valid) && ($past(temp) < RELEASE));

   // R6: no strobe, no change
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(act_q));
endmodule

// File: rtl/thermal_gate_mask.sv
module thermal_gate_mask #(
   parameter int N_SW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic [N_SW-1:0] req,
   output logic [N_SW-1:0] gate
);
   if (N_SW < 1) begin : g_bad_n
      $error("thermal_gate_mask: N_SW must be at least 1");
   end

   for (genvar i = 0; i < N_SW; i++) begin : g_sw
      assign gate[i] = req[i] & ~kill;
   end

   // R7
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill |-> (gate == '0));
   // R8
   gate_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !kill |-> (gate == req));
endmodule

// File: rtl/thermal_supervisor.sv
module thermal_supervisor
   import thermal_sup_pkg::*;
#(
   parameter int TEMP_W    = 10,
   parameter int WARN_TRIP = 150,
   parameter int WARN_HYST = 15,
   parameter int SHDN_TRIP = 180,
   parameter int SHDN_HYST = 25
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     temp_valid,
   input  logic signed [TEMP_W-1:0] temp_c,
   input  logic                     hs_req,
   input  logic                     ls_req,
   output logic                     warn_n,
   output logic                     shdn_req,
   output logic                     hs_gate,
   output logic                     ls_gate
);
   localparam int N_SW = 2;

   if (TEMP_W < 4) begin : g_bad_w
      $error("thermal_supervisor: TEMP_W too small");
   end

   logic            warn_act, shdn_act;
   logic [N_SW-1:0] req_v, gate_v;

   thermal_hyst_cmp #(
      .TEMP_W(TEMP_W), .TRIP(WARN_TRIP), .HYST(WARN_HYST), .MODE(TRIP_AT_OR_ABOVE)
   ) u_warn (
      .clk(clk), .rst_n(rst_n), .valid(temp_valid), .temp(temp_c), .active(warn_act)
   );

   thermal_hyst_cmp #(
      .TEMP_W(TEMP_W), .TRIP(SHDN_TRIP), .HYST(SHDN_HYST), .MODE(TRIP_ABOVE)
   ) u_shdn (
      .clk(clk), .rst_n(rst_n), .valid(temp_valid), .temp(temp_c), .active(shdn_act)
   );

   assign req_v = {hs_req, ls_req};

   thermal_gate_mask #(.N_SW(N_SW)) u_mask (
      .clk(clk), .rst_n(rst_n), .kill(shdn_act), .req(req_v), .gate(gate_v)
   );

   assign warn_n   = ~warn_act;
   assign shdn_req = shdn_act;
   assign hs_gate  = gate_v[1];
   assign ls_gate  = gate_v[0];

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> (warn_n && !shdn_req));
endmodule

// File: tb/thermal_supervisor_bench.sv
module thermal_supervisor_bench;
   localparam int W = 10;
   localparam int WT = 150, WR = 135, ST = 180, SR = 155;

   logic clk = 1'b0, rst_n = 1'b0, temp_valid = 1'b0, hs_req = 1'b0, ls_req = 1'b0;
   logic signed [W-1:0] temp_c = '0;
   logic warn_n, shdn_req, hs_gate, ls_gate;

   int  n_chk = 0, n_bad = 0;
   bit  m_warn = 1'b0, m_shdn = 1'b0;

   always #5 clk = ~clk;

   thermal_supervisor u_thermal_supervisor (
      .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_c(temp_c),
      .hs_req(hs_req), .ls_req(ls_req), .warn_n(warn_n), .shdn_req(shdn_req),
      .hs_gate(hs_gate), .ls_gate(ls_gate)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive one sample; check gates before the edge, states after it
   task automatic step(input int t, input bit v, input bit h, input bit l, input string tag);
      @(negedge clk);
      temp_c = t[W-1:0]; temp_valid = v; hs_req = h; ls_req = l;
      #1;
      chk({tag, " R7/R8 hs_gate"}, hs_gate, h & ~m_shdn);
      chk({tag, " R7/R8 ls_gate"}, ls_gate, l & ~m_shdn);
      @(posedge clk);
      if (v) begin
         if (!m_warn && t >= WT) m_warn = 1'b1;
         else if (m_warn && t < WR) m_warn = 1'b0;
         if (!m_shdn && t > ST) m_shdn = 1'b1;
         else if (m_shdn && t < SR) m_shdn = 1'b0;
      end
      #1;
      chk({tag, " warn_n"}, warn_n, ~m_warn);
      chk({tag, " shdn_req"}, shdn_req, m_shdn);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 warn_n", warn_n, 1'b1);
      chk("R1 shdn_req", shdn_req, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      step(149, 1, 1, 0, "R2 below");      chk("R2 149", warn_n, 1'b1);
      step(150, 1, 1, 0, "R2 trip");       chk("R2 150", warn_n, 1'b0);
      step(25,  0, 0, 1, "R6 idle");       chk("R6 cold ignored", warn_n, 1'b0);
      step(140, 1, 1, 1, "R8 warn");       chk("R8 hs passes", hs_gate, 1'b1);
      step(135, 1, 0, 1, "R3 equal");      chk("R3 135 holds", warn_n, 1'b0);
      step(134, 1, 0, 1, "R3 release");    chk("R3 134", warn_n, 1'b1);
      step(190, 0, 1, 1, "R6 hot idle");   chk("R6 hot ignored", shdn_req, 1'b0);
      step(180, 1, 1, 1, "R4 equal");      chk("R4 180 no trip", shdn_req, 1'b0);
      step(181, 1, 1, 1, "R4 trip");       chk("R4 181", shdn_req, 1'b1);
      step(170, 1, 1, 1, "R7 forced");     chk("R7 hs off", hs_gate, 1'b0);
      chk("R7 ls off", ls_gate, 1'b0);
      step(155, 1, 1, 0, "R5 equal");      chk("R5 155 holds", shdn_req, 1'b1);
      step(154, 1, 1, 0, "R9 split");      chk("R5 154", shdn_req, 1'b0);
      chk("R9 warn still set", warn_n, 1'b0);
      step(100, 1, 0, 0, "cool");

      // Sweep up then down with a strobe that skips samples
      for (int t = -40; t <= 200; t++) step(t, (t % 3) != 0, t[0], t[1], "sweep up");
      for (int t = 200; t >= -40; t--) step(t, (t % 4) != 1, t[1], t[0], "sweep down");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule